// File: doc/BRIEF.md
# Burst Read Configuration and Sequencer

This block holds the read-mode settings of a synchronous-burst memory and produces the word-address sequence for each burst. The settings are not taken from a data bus. When `cfg_load` is pulsed, the block samples a group of bits on the address bus and stores them. After that, each access begins while `addr_strobe` is high: the block latches the start address from `start_addr`. When the strobe drops, the block either presents that address immediately (asynchronous mode) or counts active edges of the burst clock `bclk` (synchronous mode). In synchronous mode it raises `data_valid` on the programmed edge and then advances `word_addr` by one word on every later active edge.

The burst clock is sampled on the fast system clock `clk`. Only transitions of the selected polarity count as active edges. Advancing is either continuous, or it wraps within an aligned block of 8, 16 or 32 words. `rdy` can rise together with `data_valid`, or one active edge before it. The output side is a plain stream with no back-pressure: the consumer cannot stall it. A word is present whenever `data_valid` is high, and `rdy` is an indicator for the consumer only. A new access starts only when `addr_strobe` is raised again.

Top module: `burst_seq_top`

## Requirements
- R1: After reset, `data_valid` is 0, `word_addr` is 0 and `rdy` is 1. The stored settings return to their defaults: asynchronous mode, ready aligned with data, rising edge, continuous burst and latency code 5.
- R2: A `cfg_load` pulse stores `start_addr` bits as follows. Bit 19 is the mode (0 synchronous, 1 asynchronous). Bit 18 is ready timing (1 aligned, 0 early). Bit 17 is edge polarity (1 rising, 0 falling). Bits 16:15 are the burst kind (00 continuous, 01 wrap 8, 10 wrap 16, 11 wrap 32). Bits 14:12 are the latency code.
- R3: In asynchronous mode `rdy` stays 1. After the strobe falls, `data_valid` is 1 and `word_addr` equals the start address, and it does not move while `bclk` toggles.
- R4: In synchronous mode with latency code n (0 to 5), `data_valid` is 0 through active edge n+1 after the strobe falls. It is 1 after edge n+2, and at that point `word_addr` equals the start address.
- R5: In synchronous mode with aligned ready timing, `rdy` equals `data_valid`.
- R6: In synchronous mode with early ready timing, `rdy` rises after active edge n+1, one active edge before `data_valid`.
- R7: Only `bclk` transitions of the selected polarity count as active edges. Transitions of the other polarity have no effect.
- R8: In continuous mode, `word_addr` increases by one on each active edge after the first data, across any power-of-two boundary. It holds between active edges.
- R9: In wrap mode of length L, each active edge increments the low log2(L) bits modulo L and leaves the upper bits unchanged.
- R10: Loading latency code 6 or 7 leaves the stored latency unchanged. All other fields of that load still take effect.
- R11: Raising `addr_strobe` during a burst ends it. `data_valid` is 0 on the cycle after the strobe is seen, and the edge count restarts from the new strobe's falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset; restores defaults |
| cfg_load | input | 1 | One-cycle pulse that stores settings from `start_addr[19:12]` |
| addr_strobe | input | 1 | High while a new start address is presented; falling starts the access |
| start_addr | input | AW | Start word address, also the settings source on `cfg_load` |
| bclk | input | 1 | Burst clock, sampled by `clk` |
| word_addr | output | AW | Current word address of the burst |
| data_valid | output | 1 | High while `word_addr` names valid data |
| rdy | output | 1 | Ready indicator for the consumer |

## Verification
The bench sweeps every legal latency code and counts active edges one at a time. A sequencer that is off by one edge shows `data_valid` one beat early or late. It also runs with falling polarity and lets the inactive transitions pass: a design that counted both transitions would reach the first data and later addresses too soon. Wrap bursts start a few words below a block boundary and continue past one full wrap, so a wrong mask either carries into the upper bits or rolls over at the wrong length. The bench also loads a reserved latency code together with a new burst kind, raises the strobe in the middle of a burst, and resets out of synchronous mode. Each of these exposes settings that are stale, lost or partly applied.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    BK_CONT   = 2'b00,
    BK_WRAP8  = 2'b01,
    BK_WRAP16 = 2'b10,
    BK_WRAP32 = 2'b11
  } burst_kind_e;

  typedef struct packed {
    logic        async_mode;
    logic        rdy_aligned;
    logic        rise_edge;
    burst_kind_e kind;
    logic [2:0]  lat;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_DEFAULT = '{
    async_mode:  1'b1,
    rdy_aligned: 1'b1,
    rise_edge:   1'b1,
    kind:        BK_CONT,
    lat:         3'd5
  };

  // bit range of start_addr that carries the settings
  localparam int CFG_LSB      = 12;
  localparam int CFG_W        = 8;
  localparam int LAT_MAX_CODE = 5;
  localparam int LAT_OFFSET   = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_WAIT,
    ST_RUN
  } seq_state_e;

endpackage

// File: rtl/burst_cfg_reg.sv
module burst_cfg_reg
  import burst_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] bits_in,
  output burst_cfg_t       cfg
);

  logic [2:0] lat_in;
  logic       lat_legal;

  assign lat_in    = bits_in[2:0];
  assign lat_legal = (int'(lat_in) <= LAT_MAX_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= CFG_DEFAULT;
    end else if (load) begin
      cfg.async_mode  <= bits_in[7];
      cfg.rdy_aligned <= bits_in[6];
      cfg.rise_edge   <= bits_in[5];
      cfg.kind        <= burst_kind_e'(bits_in[4:3]);
      if (lat_legal) cfg.lat <= lat_in;
    end
  end

endmodule

// File: rtl/burst_edge_det.sv
module burst_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk,
  input  logic rise_sel,
  output logic tick
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], bclk};
      prev_q <= cur;
    end
  end

  assign tick = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic [AW-1:0] cur,
  input  burst_kind_e   kind,
  output logic [AW-1:0] nxt
);

  localparam int NWRAP = 3;

  logic [AW-1:0] wrapped [NWRAP];

  for (genvar g = 0; g < NWRAP; g++) begin : g_wrap
    localparam int LB = 3 + g;
    logic [LB-1:0] low_inc;
    assign low_inc    = cur[LB-1:0] + 1'b1;
    assign wrapped[g] = {cur[AW-1:LB], low_inc};
  end

  always_comb begin
    unique case (kind)
      BK_WRAP8:  nxt = wrapped[0];
      BK_WRAP16: nxt = wrapped[1];
      BK_WRAP32: nxt = wrapped[2];
      default:   nxt = cur + 1'b1;
    endcase
  end

endmodule

// File: rtl/burst_seq_top.sv
module burst_seq_top
  import burst_seq_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          addr_strobe,
  input  logic [AW-1:0] start_addr,
  input  logic          bclk,
  output logic [AW-1:0] word_addr,
  output logic          data_valid,
  output logic          rdy
);

  localparam int CNT_W = 4;

  burst_cfg_t    cfg;
  logic          tick;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] addr_nxt;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;
  logic [CNT_W-1:0] first_edge;
  logic          dv_q;
  logic          pre_q;
  seq_state_e    st_q;

  burst_cfg_reg i_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .bits_in (start_addr[CFG_LSB+CFG_W-1:CFG_LSB]),
    .cfg     (cfg)
  );

  burst_edge_det #(.SYNC_STAGES(2)) i_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (bclk),
    .rise_sel (cfg.rise_edge),
    .tick     (tick)
  );

  burst_addr_step #(.AW(AW)) i_step (
    .cur  (addr_q),
    .kind (cfg.kind),
    .nxt  (addr_nxt)
  );

  assign cnt_inc    = cnt_q + 1'b1;
  assign first_edge = {1'b0, cfg.lat} + CNT_W'(LAT_OFFSET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      dv_q   <= 1'b0;
      pre_q  <= 1'b0;
    end else if (addr_strobe) begin
      st_q   <= ST_LOAD;
      addr_q <= start_addr;
      cnt_q  <= '0;
      dv_q   <= 1'b0;
      pre_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_LOAD: begin
          if (cfg.async_mode) begin
            st_q <= ST_RUN;
            dv_q <= 1'b1;
          end else begin
            st_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (tick) begin
            cnt_q <= cnt_inc;
            if (cnt_inc == first_edge - 1'b1) pre_q <= 1'b1;
            if (cnt_inc == first_edge) begin
              st_q <= ST_RUN;
              dv_q <= 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (tick && !cfg.async_mode) addr_q <= addr_nxt;
        end
        default: ;
      endcase
    end
  end

  assign word_addr  = addr_q;
  assign data_valid = dv_q;
  assign rdy        = cfg.async_mode ? 1'b1
                    : (cfg.rdy_aligned ? dv_q : (dv_q | pre_q));

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr_strobe,
  input logic          data_valid,
  input logic          rdy,
  input logic [AW-1:0] word_addr,
  input logic          tick,
  input logic          async_mode,
  input logic          rdy_aligned,
  input logic [1:0]    kind
);

  // R3
  async_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    async_mode |-> rdy);

  // R3
  async_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (async_mode && $past(async_mode) && data_valid && $past(data_valid)
     && !$past(addr_strobe)) |-> $stable(word_addr));

  // R11
  strobe_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_strobe |=> !data_valid);

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid) && !$past(tick) && !$past(addr_strobe))
    |-> $stable(word_addr));

  // R9
  wrap_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != 2'b00 && $past(kind) == kind && data_valid && $past(data_valid)
     && !$past(addr_strobe)) |-> (word_addr[AW-1:5] == $past(word_addr[AW-1:5])));

  // R5
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && rdy_aligned) |-> (rdy == data_valid));

  // R6
  early_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!async_mode && !rdy_aligned && $rose(data_valid)) |-> $past(rdy));

endmodule

bind burst_seq_top burst_seq_chk #(.AW(AW)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .addr_strobe (addr_strobe),
  .data_valid  (data_valid),
  .rdy         (rdy),
  .word_addr   (word_addr),
  .tick        (tick),
  .async_mode  (cfg.async_mode),
  .rdy_aligned (cfg.rdy_aligned),
  .kind        (cfg.kind)
);

// File: tb/test_burst_seq_top.sv
`timescale 1ns/1ps
module test_burst_seq_top;

  localparam int AW   = 20;
  localparam int HOLD = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_load = 1'b0;
  logic          addr_strobe = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          bclk = 1'b0;
  logic [AW-1:0] word_addr;
  logic          data_valid;
  logic          rdy;

  int errors = 0;
  int checks = 0;
  bit done   = 0;
  bit cur_rise = 1'b1;

  always #2.5 clk = ~clk;

  burst_seq_top #(.AW(AW)) i_burst_seq_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_load    (cfg_load),
    .addr_strobe (addr_strobe),
    .start_addr  (start_addr),
    .bclk        (bclk),
    .word_addr   (word_addr),
    .data_valid  (data_valid),
    .rdy         (rdy)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] s,
                                             input int beat, input int kind);
    logic [AW-1:0] m;
    if (kind == 0) return s + AW'(beat);
    m = AW'((8 << (kind - 1)) - 1);
    return (s & ~m) | ((s + AW'(beat)) & m);
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
  endtask

  // async, aligned, rise, kind, lat
  task automatic cfg_write(input bit asy, input bit algn, input bit rise,
                           input int kind, input int lat);
    logic [AW-1:0] a;
    a = '0;
    a[19] = asy;
    a[18] = algn;
    a[17] = rise;
    a[16:15] = 2'(kind);
    a[14:12] = 3'(lat);
    start_addr = a;
    cfg_load   = 1'b1;
    wait_clk(1);
    cfg_load   = 1'b0;
    cur_rise   = rise;
    wait_clk(1);
  endtask

  task automatic start(input logic [AW-1:0] a);
    bclk = ~cur_rise;
    wait_clk(HOLD);
    start_addr  = a;
    addr_strobe = 1'b1;
    wait_clk(2);
    addr_strobe = 1'b0;
    wait_clk(3);
  endtask

  // one active edge of the selected polarity, then settle
  task automatic beat();
    bclk = ~cur_rise;
    wait_clk(HOLD);
    bclk = cur_rise;
    wait_clk(HOLD);
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R1", "data_valid after reset", 32'(data_valid), 0);
    chk("R1", "word_addr after reset", 32'(word_addr), 0);
    chk("R1", "rdy after reset", 32'(rdy), 1);
  endtask

  task automatic t_async();
    do_reset();
    start(20'h3_4567);
    chk("R3", "async data_valid", 32'(data_valid), 1);
    chk("R3", "async addr", 32'(word_addr), 32'h3_4567);
    for (int i = 0; i < 3; i++) beat();
    chk("R3", "async addr after bclk toggles", 32'(word_addr), 32'h3_4567);
    chk("R3", "async rdy", 32'(rdy), 1);
  endtask

  task automatic t_latency();
    for (int c = 0; c <= 5; c++) begin
      cfg_write(0, 1, 1, 0, c);
      start(20'h0_0100);
      for (int k = 1; k <= c + 2; k++) begin
        beat();
        chk("R4", $sformatf("code %0d dv at edge %0d", c, k),
            32'(data_valid), 32'(k >= c + 2));
        chk("R5", $sformatf("code %0d rdy at edge %0d", c, k),
            32'(rdy), 32'(k >= c + 2));
      end
      chk("R4", $sformatf("code %0d first addr", c), 32'(word_addr), 32'h100);
    end
  endtask

  task automatic t_early();
    cfg_write(0, 0, 1, 0, 1);
    start(20'h0_0040);
    beat();
    chk("R6", "rdy edge1", 32'(rdy), 0);
    beat();
    chk("R6", "rdy edge2", 32'(rdy), 1);
    chk("R6", "dv edge2", 32'(data_valid), 0);
    beat();
    chk("R6", "dv edge3", 32'(data_valid), 1);
    chk("R6", "rdy edge3", 32'(rdy), 1);
  endtask

  task automatic t_falling();
    cfg_write(0, 1, 0, 0, 0);
    start(20'h0_0200);
    beat();
    chk("R7", "falling dv edge1", 32'(data_valid), 0);
    beat();
    chk("R7", "falling dv edge2", 32'(data_valid), 1);
    chk("R7", "falling addr edge2", 32'(word_addr), 32'h200);
    beat();
    chk("R7", "falling addr edge3", 32'(word_addr), 32'h201);
  endtask

  task automatic t_continuous();
    cfg_write(0, 1, 1, 0, 0);
    start(20'h0_FFFE);
    beat();
    beat();
    for (int b = 0; b < 4; b++) begin
      chk("R8", $sformatf("cont beat %0d", b), 32'(word_addr),
          32'(exp_addr(20'h0_FFFE, b, 0)));
      if (b < 3) beat();
    end
  endtask

  task automatic t_wrap();
    for (int kd = 1; kd <= 3; kd++) begin
      cfg_write(0, 1, 1, kd, 0);
      start(20'h0_0A5D);
      beat();
      beat();
      for (int b = 0; b < (8 << (kd - 1)) + 3; b++) begin
        chk("R9", $sformatf("wrap kind %0d beat %0d", kd, b), 32'(word_addr),
            32'(exp_addr(20'h0_0A5D, b, kd)));
        beat();
      end
    end
  endtask

  task automatic t_reserved();
    cfg_write(0, 1, 1, 0, 1);
    cfg_write(0, 1, 1, 1, 6);
    start(20'h0_0306);
    beat();
    beat();
    chk("R10", "reserved code kept: dv edge2", 32'(data_valid), 0);
    beat();
    chk("R10", "reserved code kept: dv edge3", 32'(data_valid), 1);
    beat();
    beat();
    chk("R10", "wrap8 still loaded", 32'(word_addr), 32'h300);
    cfg_write(0, 1, 1, 0, 7);
    start(20'h0_0010);
    beat();
    beat();
    chk("R10", "code 7 ignored: dv edge2", 32'(data_valid), 0);
    beat();
    chk("R10", "code 7 ignored: dv edge3", 32'(data_valid), 1);
  endtask

  task automatic t_abort();
    cfg_write(0, 1, 1, 0, 0);
    start(20'h0_0500);
    beat();
    beat();
    beat();
    chk("R11", "burst running", 32'(word_addr), 32'h501);
    start_addr  = 20'h0_0700;
    addr_strobe = 1'b1;
    wait_clk(2);
    chk("R11", "dv low during strobe", 32'(data_valid), 0);
    addr_strobe = 1'b0;
    wait_clk(3);
    beat();
    chk("R11", "restart dv edge1", 32'(data_valid), 0);
    beat();
    chk("R11", "restart dv edge2", 32'(data_valid), 1);
    chk("R11", "restart addr", 32'(word_addr), 32'h700);
  endtask

  task automatic t_reset_defaults();
    cfg_write(0, 0, 0, 2, 0);
    do_reset();
    cur_rise = 1'b1;
    chk("R1", "rdy after reset from sync", 32'(rdy), 1);
    start(20'h0_0123);
    chk("R1", "default async dv", 32'(data_valid), 1);
    beat();
    beat();
    chk("R1", "default async addr", 32'(word_addr), 32'h123);
  endtask

  task automatic t_cfg_fields();
    // R2: every field taken from its own address bit
    cfg_write(0, 0, 0, 3, 0);
    start(20'h0_001E);
    beat();
    chk("R2", "early ready from bit18", 32'(rdy), 1);
    beat();
    beat();
    beat();
    chk("R2", "wrap32 and falling from bits 17:15", 32'(word_addr), 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    t_reset_state();
    t_async();
    t_latency();
    t_early();
    t_falling();
    t_continuous();
    t_wrap();
    t_reserved();
    t_abort();
    t_cfg_fields();
    t_reset_defaults();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

endmodule